// File: doc/BRIEF.md
# Two-Byte Accumulator Processor Core

This block is a compact 8-bit processor built around an accumulator. Besides the accumulator it holds two working registers, a 10-bit program counter, and a zero flag and a carry flag that programs can test. Each instruction is two bytes long. The core reads both bytes through a single memory port, decodes them and executes one of sixteen operations: load, store, add, subtract, invert, exclusive-or, shift, flag clears, unconditional and conditional jumps, and halt.

The memory on the other side of the port is synchronous. An address presented in one cycle returns its byte on the read-data input in the next cycle. Writes use the same address lines and are qualified by a write strobe. An instruction takes four cycles: address issue, opcode byte, argument byte, execute. The flags that jumps test are published only by a store. Arithmetic leaves behind a pending carry, and the store copies it into the visible flag.

Top module: `acc_cpu`

## Requirements
- R1: The first instruction byte carries the opcode in bits 7..4, an operand selector in bits 3..2 and a page number in bits 1..0. The second byte is the argument. Selector 00 picks working register B, 01 picks working register C, 10 picks the argument byte itself, and 11 picks memory at the 10-bit address {page, argument}.
- R2: While reset is held, the memory address is 0, the write strobe is low and the halted output is low. Reset clears the accumulator, B, C, the program counter, both flags and the pending carry.
- R3: Opcode 1 (load) copies the selected operand into the accumulator. For example, the bytes 0x18 0x0E leave the accumulator at 0x0E.
- R4: Opcode 2 (store) writes the accumulator into B, C or memory at {page, argument}, according to the selector. With selector 10 it writes nothing anywhere.
- R5: Opcode 3 (add) sets the accumulator to (A + operand) mod 256 and sets the pending carry to the carry out of bit 7.
- R6: Opcode 4 (subtract) sets the accumulator to (A − operand) mod 256 and sets the pending carry to 1 exactly when no borrow occurs (A >= operand).
- R7: Opcode 5 replaces the accumulator with its bitwise inverse. Opcode 6 exclusive-ors the operand into the accumulator. Neither changes the pending carry.
- R8: Opcode 7 shifts the accumulator left by one place, puts 0 in bit 0 and moves the old bit 7 into the pending carry.
- R9: Only a store changes the visible flags. It sets zero to (accumulator == 0) and copies the pending carry into carry. No other opcode changes them, except the clears in R10.
- R10: Opcode 8 clears the visible carry and the pending carry. Opcode 9 clears the visible zero flag.
- R11: Opcode 10 loads the program counter with {page, argument}. Opcodes 11, 12, 13 and 14 do the same only when zero is set, zero is clear, carry is set or carry is clear, respectively. Otherwise execution continues with the next instruction.
- R12: Opcode 15 raises the halted output. Once halted, the core fetches and writes nothing until reset. After reset it runs again from address 0.
- R13: Opcode 0 changes no register, flag or memory location, whatever its selector and argument.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 10 | Memory address for fetch, operand read and store |
| mem_rdata | input | 8 | Byte returned by memory one cycle after its address |
| mem_wdata | output | 8 | Byte to be written (the accumulator) |
| mem_we | output | 1 | Memory write strobe |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A store publishing the flags and a conditional jump reading them can occupy adjacent execute slots. In that case the jump has to see the values the store just produced. Every sweep program therefore places flag probes (a load, two conditional jumps, and exclusive-ors that record which jumps fell through) directly behind a store. The probe also ends with its own store, so a second probe shows whether that store republished the pending carry. The bench computes the expected sum, difference, shift and flag pattern arithmetically for every operand pair, and compares them with the bytes the program leaves in memory.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 4;
   localparam int SRC_W = 2;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP   = 4'h0,
      OP_LOAD  = 4'h1,
      OP_STORE = 4'h2,
      OP_ADD   = 4'h3,
      OP_SUB   = 4'h4,
      OP_INV   = 4'h5,
      OP_XOR   = 4'h6,
      OP_SHL   = 4'h7,
      OP_CLRC  = 4'h8,
      OP_CLRZ  = 4'h9,
      OP_JUMP  = 4'hA,
      OP_JZ    = 4'hB,
      OP_JNZ   = 4'hC,
      OP_JC    = 4'hD,
      OP_JNC   = 4'hE,
      OP_HALT  = 4'hF
   } opcode_e;

   typedef enum logic [SRC_W-1:0] {
      SRC_B   = 2'b00,
      SRC_C   = 2'b01,
      SRC_IMM = 2'b10,
      SRC_MEM = 2'b11
   } src_e;

   typedef enum logic [2:0] {
      PH_ISSUE,
      PH_OPC,
      PH_ARG,
      PH_EXEC,
      PH_HALT
   } phase_e;

   typedef struct packed {
      opcode_e opc;
      src_e    src;
      logic    is_jump;
      logic    is_cond;
      logic    alu_acc;
      logic    alu_carry;
   } ctrl_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 2
) (
   input  logic [DATA_W-1:0] instr,
   output ctrl_t             ctrl,
   output logic [PAGE_W-1:0] page
);

   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam int SRC_LSB = PAGE_W;

   if (OPC_W + SRC_W + PAGE_W != DATA_W) begin : g_bad_fields
      $error("acc_cpu_decode: opcode, selector and page must fill one byte");
   end

   always_comb begin
      ctrl.opc       = opcode_e'(instr[OPC_LSB +: OPC_W]);
      ctrl.src       = src_e'(instr[SRC_LSB +: SRC_W]);
      ctrl.is_jump   = ctrl.opc inside {OP_JUMP, OP_JZ, OP_JNZ, OP_JC, OP_JNC};
      ctrl.is_cond   = ctrl.opc inside {OP_JZ, OP_JNZ, OP_JC, OP_JNC};
      ctrl.alu_acc   = ctrl.opc inside {OP_ADD, OP_SUB, OP_INV, OP_XOR, OP_SHL};
      ctrl.alu_carry = ctrl.opc inside {OP_ADD, OP_SUB, OP_SHL};
      page           = instr[PAGE_W-1:0];
   end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  opcode_e           opc,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] result,
   output logic              carry
);

   localparam int WIDE_W = DATA_W + 1;

   logic [WIDE_W-1:0] wide;

   always_comb begin
      case (opc)
         OP_ADD:  wide = {1'b0, a} + {1'b0, b};
         OP_SUB:  wide = {1'b0, a} + {1'b0, ~b} + WIDE_W'(1);
         OP_INV:  wide = {1'b0, ~a};
         OP_XOR:  wide = {1'b0, a ^ b};
         OP_SHL:  wide = {a, 1'b0};
         default: wide = {1'b0, a};
      endcase
      result = wide[DATA_W-1:0];
      carry  = wide[DATA_W];
   end

endmodule

// File: rtl/acc_cpu_regbank.sv
module acc_cpu_regbank #(
   parameter int DATA_W = 8,
   parameter int NREG   = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   we,
   input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] widx,
   input  logic [DATA_W-1:0]                      wdata,
   input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] ridx,
   output logic [DATA_W-1:0]                      rdata
);

   localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

   if (NREG != (1 << IDX_W)) begin : g_bad_nreg
      $error("acc_cpu_regbank: NREG must be a power of two");
   end

   logic [DATA_W-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[g] <= '0;
         end else if (we && widx == IDX_W'(g)) begin
            regs[g] <= wdata;
         end
      end

      // R4: a register keeps its value unless a store names it
      p_reg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && widx == IDX_W'(g)) |=> $stable(regs[g]));
   end

   assign rdata = regs[ridx];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 2,
   parameter int NREG   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   output logic [DATA_W+PAGE_W-1:0]   mem_addr,
   input  logic [DATA_W-1:0]          mem_rdata,
   output logic [DATA_W-1:0]          mem_wdata,
   output logic                       mem_we,
   output logic                       halted
);

   localparam int ADDR_W = DATA_W + PAGE_W;
   localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;

   if (NREG != 2) begin : g_bad_bank
      $error("acc_cpu: the selector addresses exactly two working registers");
   end

   phase_e              phase_q;
   logic [ADDR_W-1:0]   pc_q;
   logic [DATA_W-1:0]   ir_q;
   logic [DATA_W-1:0]   arg_q;
   logic [DATA_W-1:0]   acc_q;
   logic                flag_z_q;
   logic                flag_c_q;
   logic                pend_c_q;

   ctrl_t               ctrl;
   logic [PAGE_W-1:0]   page;
   logic [ADDR_W-1:0]   target;
   logic [DATA_W-1:0]   operand;
   logic [DATA_W-1:0]   bank_rd;
   logic [DATA_W-1:0]   alu_res;
   logic                alu_c;
   logic                cond_met;
   logic                jump_take;
   logic                exec;
   logic                bank_we;

   acc_cpu_decode #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) decode_i (
      .instr (ir_q),
      .ctrl  (ctrl),
      .page  (page)
   );

   acc_cpu_regbank #(.DATA_W(DATA_W), .NREG(NREG)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .widx  (IDX_W'(ctrl.src[0])),
      .wdata (acc_q),
      .ridx  (IDX_W'(ctrl.src[0])),
      .rdata (bank_rd)
   );

   acc_cpu_alu #(.DATA_W(DATA_W)) alu_i (
      .opc    (ctrl.opc),
      .a      (acc_q),
      .b      (operand),
      .result (alu_res),
      .carry  (alu_c)
   );

   assign target = {page, arg_q};
   assign exec   = (phase_q == PH_EXEC);

   always_comb begin
      case (ctrl.src)
         SRC_B, SRC_C: operand = bank_rd;
         SRC_IMM:      operand = arg_q;
         default:      operand = mem_rdata;
      endcase
   end

   always_comb begin
      case (ctrl.opc)
         OP_JZ:   cond_met = flag_z_q;
         OP_JNZ:  cond_met = !flag_z_q;
         OP_JC:   cond_met = flag_c_q;
         OP_JNC:  cond_met = !flag_c_q;
         default: cond_met = 1'b1;
      endcase
      jump_take = ctrl.is_jump && (!ctrl.is_cond || cond_met);
   end

   assign bank_we = exec && ctrl.opc == OP_STORE &&
                    (ctrl.src == SRC_B || ctrl.src == SRC_C);
   assign mem_we  = exec && ctrl.opc == OP_STORE && ctrl.src == SRC_MEM;

   always_comb begin
      case (phase_q)
         PH_OPC:  mem_addr = pc_q + ADDR_W'(1);
         PH_ARG:  mem_addr = {page, mem_rdata};
         PH_EXEC: mem_addr = target;
         default: mem_addr = pc_q;
      endcase
   end

   assign mem_wdata = acc_q;
   assign halted    = (phase_q == PH_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_ISSUE;
         pc_q     <= '0;
         ir_q     <= '0;
         arg_q    <= '0;
         acc_q    <= '0;
         flag_z_q <= 1'b0;
         flag_c_q <= 1'b0;
         pend_c_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_ISSUE: phase_q <= PH_OPC;
            PH_OPC: begin
               ir_q    <= mem_rdata;
               pc_q    <= pc_q + ADDR_W'(1);
               phase_q <= PH_ARG;
            end
            PH_ARG: begin
               arg_q   <= mem_rdata;
               pc_q    <= pc_q + ADDR_W'(1);
               phase_q <= PH_EXEC;
            end
            PH_EXEC: begin
               phase_q <= PH_ISSUE;
               if (jump_take) pc_q <= target;
               if (ctrl.alu_acc) acc_q <= alu_res;
               if (ctrl.alu_carry) pend_c_q <= alu_c;
               case (ctrl.opc)
                  OP_LOAD:  acc_q <= operand;
                  OP_STORE: begin
                     flag_z_q <= (acc_q == '0);
                     flag_c_q <= pend_c_q;
                  end
                  OP_CLRC: begin
                     flag_c_q <= 1'b0;
                     pend_c_q <= 1'b0;
                  end
                  OP_CLRZ:  flag_z_q <= 1'b0;
                  OP_HALT:  phase_q  <= PH_HALT;
                  default: ;
               endcase
            end
            default: phase_q <= PH_HALT;
         endcase
      end
   end

   // R12: halt persists and never writes
   p_halt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && !mem_we);

   // R9: visible flags move only on store or clear
   p_flags_only_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec || !(ctrl.opc inside {OP_STORE, OP_CLRC, OP_CLRZ}))
      |=> $stable(flag_z_q) && $stable(flag_c_q));

   // R4: immediate-selector store writes nowhere
   p_store_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && ctrl.opc == OP_STORE && ctrl.src == SRC_IMM) |-> !mem_we && !bank_we);

   // R11: taken jump lands on {page, argument}
   p_jump_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && jump_take) |=> pc_q == $past(target));

   // R11: failed condition falls through
   p_fallthrough_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && ctrl.is_cond && !cond_met) |=> $stable(pc_q));

   // R6: subtract carry means no borrow
   p_sub_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && ctrl.opc == OP_SUB) |=> pend_c_q == ($past(acc_q) >= $past(operand)));

   // R8: shift moves bit 7 to carry and clears bit 0
   p_shl_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && ctrl.opc == OP_SHL) |=> pend_c_q == $past(acc_q[DATA_W-1]) && !acc_q[0]);

endmodule

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;

   localparam logic [3:0] C_NOP = 4'h0, C_LD = 4'h1, C_ST = 4'h2, C_ADD = 4'h3,
                          C_SUB = 4'h4, C_INV = 4'h5, C_XOR = 4'h6, C_SHL = 4'h7,
                          C_CLRC = 4'h8, C_CLRZ = 4'h9, C_JMP = 4'hA, C_JZ = 4'hB,
                          C_JNZ = 4'hC, C_JC = 4'hD, C_JNC = 4'hE, C_HALT = 4'hF;
   localparam logic [1:0] S_B = 2'b00, S_C = 2'b01, S_IMM = 2'b10, S_MEM = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  mem_addr;
   logic [7:0]  mem_rdata = 8'h00;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic        halted;
   logic [7:0]  mem [0:1023];

   int n_checks = 0;
   int n_fail = 0;
   int wp = 0;

   always #10 clk = ~clk;

   acc_cpu #(.DATA_W(8), .PAGE_W(2), .NREG(2)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .halted    (halted)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      wp = 0;
   endtask

   task automatic emit(input logic [3:0] op, input logic [1:0] sel, input logic [9:0] arg);
      mem[wp]     = {op, sel, arg[9:8]};
      mem[wp + 1] = arg[7:0];
      wp += 2;
   endtask

   // stores {cond on carry fell through, cond on zero fell through}
   task automatic emit_probe(input logic [3:0] jz, input logic [3:0] jc, input logic [9:0] dst);
      int b;
      b = wp;
      emit(C_LD, S_IMM, 10'h000);
      emit(jz, S_MEM, 10'(b + 6));
      emit(C_XOR, S_IMM, 10'h001);
      emit(jc, S_MEM, 10'(b + 10));
      emit(C_XOR, S_IMM, 10'h002);
      emit(C_ST, S_MEM, dst);
   endtask

   task automatic run(input string req);
      int k;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      k = 0;
      while (!halted && k < 2000) begin
         @(negedge clk);
         k++;
      end
      if (!halted) begin
         n_checks++;
         n_fail++;
         $display("FAIL %s: actual no-halt expected halt", req);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int a, b, s, z, c, bad;
      logic [9:0] addr0;
      clear_mem();
      @(negedge clk);
      // R2: port state under reset
      check("R2 reset addr", mem_addr, 0);
      check("R2 reset we", mem_we, 0);
      check("R2 reset halted", halted, 0);

      // R3: example load of 0x0E
      clear_mem();
      emit(C_LD, S_IMM, 10'h00E);
      emit(C_ST, S_MEM, 10'h100);
      emit(C_HALT, S_B, 10'h000);
      run("R3 example");
      check("R3 example load", mem[10'h100], 8'h0E);

      // R4 R3 R1: working registers B and C
      clear_mem();
      emit(C_LD, S_IMM, 10'h005);
      emit(C_ST, S_B, 10'h000);
      emit(C_LD, S_IMM, 10'h009);
      emit(C_ST, S_C, 10'h000);
      emit(C_LD, S_B, 10'h000);
      emit(C_ST, S_MEM, 10'h100);
      emit(C_LD, S_C, 10'h000);
      emit(C_ADD, S_B, 10'h000);
      emit(C_ST, S_MEM, 10'h3FE);
      emit(C_HALT, S_B, 10'h000);
      run("R4 regs");
      check("R4 store/load B", mem[10'h100], 8'h05);
      check("R1 add C+B to page 3", mem[10'h3FE], 8'h0E);

      // R2: registers and flags cleared by reset
      clear_mem();
      emit_probe(C_JZ, C_JC, 10'h100);
      emit(C_LD, S_B, 10'h000);
      emit(C_ST, S_MEM, 10'h101);
      emit(C_LD, S_C, 10'h000);
      emit(C_ST, S_MEM, 10'h102);
      emit(C_HALT, S_B, 10'h000);
      mem[10'h101] = 8'hEE;
      mem[10'h102] = 8'hEE;
      run("R2 regs");
      check("R2 flags clear", mem[10'h100], 3);
      check("R2 B clear", mem[10'h101], 0);
      check("R2 C clear", mem[10'h102], 0);
      clear_mem();
      emit(C_ST, S_MEM, 10'h100);
      emit_probe(C_JZ, C_JC, 10'h101);
      emit(C_HALT, S_B, 10'h000);
      mem[10'h100] = 8'hEE;
      run("R2 acc");
      check("R2 acc clear", mem[10'h100], 0);
      check("R2 pending carry clear", mem[10'h101], 2);

      // R1 R3: paged memory operand
      clear_mem();
      mem[10'h2A3] = 8'h77;
      emit(C_LD, S_MEM, 10'h2A3);
      emit(C_ST, S_MEM, 10'h100);
      emit(C_HALT, S_B, 10'h000);
      run("R1 mem");
      check("R1 paged load", mem[10'h100], 8'h77);

      // R4: immediate store writes nothing
      clear_mem();
      emit(C_LD, S_IMM, 10'h055);
      emit(C_ST, S_B, 10'h000);
      emit(C_LD, S_IMM, 10'h066);
      emit(C_ST, S_C, 10'h000);
      emit(C_LD, S_IMM, 10'h0AA);
      emit(C_ST, S_IMM, 10'h000);
      emit(C_ST, S_IMM, 10'h3FF);
      emit(C_LD, S_B, 10'h000);
      emit(C_ST, S_MEM, 10'h100);
      emit(C_LD, S_C, 10'h000);
      emit(C_ST, S_MEM, 10'h101);
      emit(C_HALT, S_B, 10'h000);
      run("R4 imm");
      check("R4 imm store B kept", mem[10'h100], 8'h55);
      check("R4 imm store C kept", mem[10'h101], 8'h66);
      check("R4 imm store mem 0x3FF", mem[10'h3FF], 0);
      check("R4 imm store mem 0x000", mem[10'h000], 8'h18);

      // R13: no-operation with memory selector
      clear_mem();
      emit(C_LD, S_IMM, 10'h05A);
      emit(C_NOP, S_MEM, 10'h300);
      emit(C_NOP, S_B, 10'h000);
      emit(C_ST, S_MEM, 10'h100);
      emit(C_HALT, S_B, 10'h000);
      run("R13");
      check("R13 acc kept", mem[10'h100], 8'h5A);
      check("R13 mem kept", mem[10'h300], 0);

      // R11: unconditional jump across pages
      clear_mem();
      emit(C_JMP, S_MEM, 10'h2F0);
      emit(C_LD, S_IMM, 10'h011);
      emit(C_ST, S_MEM, 10'h100);
      wp = 10'h2F0;
      emit(C_LD, S_IMM, 10'h022);
      emit(C_ST, S_MEM, 10'h101);
      emit(C_HALT, S_B, 10'h000);
      run("R11 jmp");
      check("R11 skipped code", mem[10'h100], 0);
      check("R11 jump target", mem[10'h101], 8'h22);

      // R9: flags wait for a store
      clear_mem();
      emit(C_LD, S_IMM, 10'h0FF);
      emit(C_ADD, S_IMM, 10'h001);
      emit_probe(C_JZ, C_JC, 10'h100);
      emit_probe(C_JZ, C_JC, 10'h101);
      emit(C_HALT, S_B, 10'h000);
      run("R9");
      check("R9 flags before store", mem[10'h100], 3);
      check("R9 carry published by store", mem[10'h101], 1);

      // R10: flag clears
      clear_mem();
      emit(C_LD, S_IMM, 10'h0FF);
      emit(C_ADD, S_IMM, 10'h001);
      emit(C_ST, S_MEM, 10'h100);
      emit(C_CLRC, S_B, 10'h000);
      emit_probe(C_JZ, C_JC, 10'h101);
      emit(C_LD, S_IMM, 10'h000);
      emit(C_ST, S_MEM, 10'h102);
      emit(C_CLRZ, S_B, 10'h000);
      emit_probe(C_JZ, C_JC, 10'h103);
      emit(C_HALT, S_B, 10'h000);
      run("R10");
      check("R10 carry cleared", mem[10'h101], 2);
      check("R10 zero cleared, pending carry cleared", mem[10'h103], 3);

      // R12: halt holds and reset restarts
      clear_mem();
      emit(C_LD, S_IMM, 10'h033);
      emit(C_ST, S_MEM, 10'h100);
      emit(C_HALT, S_B, 10'h000);
      emit(C_LD, S_IMM, 10'h044);
      emit(C_ST, S_MEM, 10'h100);
      run("R12");
      check("R12 nothing after halt", mem[10'h100], 8'h33);
      addr0 = mem_addr;
      bad = 0;
      repeat (50) begin
         @(negedge clk);
         if (!halted || mem_we || mem_addr !== addr0) bad++;
      end
      check("R12 halt hold", bad, 0);
      mem[10'h100] = 8'h00;
      run("R12 restart");
      check("R12 restart after reset", mem[10'h100], 8'h33);

      // R5 R9 R11: add sweep, zero/carry-set probes
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            a = i * 17;
            b = j * 17;
            clear_mem();
            emit(C_LD, S_IMM, 10'(a));
            emit(C_ADD, S_IMM, 10'(b));
            emit(C_ST, S_MEM, 10'h100);
            emit_probe(C_JZ, C_JC, 10'h101);
            emit(C_HALT, S_B, 10'h000);
            run("R5 sweep");
            s = (a + b) & 255;
            c = (a + b) > 255 ? 1 : 0;
            z = (s == 0) ? 1 : 0;
            check("R5 sum", mem[10'h100], s);
            check("R9 R11 add flags", mem[10'h101], ((1 - c) << 1) | (1 - z));
         end
      end

      // R6 R11: subtract sweep from paged memory, zero/carry-clear probes
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            a = i * 17;
            b = (j * 17 + i) & 255;
            clear_mem();
            mem[10'h3C5] = 8'(b);
            emit(C_LD, S_IMM, 10'(a));
            emit(C_SUB, S_MEM, 10'h3C5);
            emit(C_ST, S_MEM, 10'h100);
            emit_probe(C_JNZ, C_JNC, 10'h101);
            emit(C_HALT, S_B, 10'h000);
            run("R6 sweep");
            s = (a - b) & 255;
            c = (a >= b) ? 1 : 0;
            z = (s == 0) ? 1 : 0;
            check("R6 difference", mem[10'h100], s);
            check("R6 R11 sub flags", mem[10'h101], (c << 1) | z);
         end
      end

      // R8: shift sweep over every accumulator value
      for (int i = 0; i < 256; i++) begin
         clear_mem();
         emit(C_LD, S_IMM, 10'(i));
         emit(C_SHL, S_B, 10'h000);
         emit(C_ST, S_MEM, 10'h100);
         emit_probe(C_JZ, C_JC, 10'h101);
         emit(C_HALT, S_B, 10'h000);
         run("R8 sweep");
         s = (i << 1) & 255;
         c = (i >> 7) & 1;
         z = (s == 0) ? 1 : 0;
         check("R8 shift", mem[10'h100], s);
         check("R8 shift flags", mem[10'h101], ((1 - c) << 1) | (1 - z));
      end

      // R7: xor through register C, then invert
      for (int i = 0; i < 16; i++) begin
         a = i * 17;
         b = (i * 37 + 5) & 255;
         clear_mem();
         emit(C_LD, S_IMM, 10'(b));
         emit(C_ST, S_C, 10'h000);
         emit(C_LD, S_IMM, 10'(a));
         emit(C_XOR, S_C, 10'h000);
         emit(C_ST, S_MEM, 10'h100);
         emit(C_INV, S_B, 10'h000);
         emit(C_ST, S_MEM, 10'h101);
         emit_probe(C_JZ, C_JC, 10'h102);
         emit(C_HALT, S_B, 10'h000);
         run("R7 sweep");
         check("R7 xor", mem[10'h100], (a ^ b) & 255);
         check("R7 invert", mem[10'h101], (~(a ^ b)) & 255);
         check("R7 carry untouched", mem[10'h102], 2 | ((((~(a ^ b)) & 255) == 0) ? 0 : 1));
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule